// File: doc/BRIEF.md
# Host Byte Port for a 16-bit Data Register

This block sits between an 8-bit external host bus and the 16-bit data register of a signal-processing core. A select input picks what a host access reaches: with the select low, the access reaches the status register; with it high, it reaches the data register. The host moves a 16-bit word either as two byte transfers, low byte first, or as single bytes that touch only the low half. A width-control bit in the status register chooses between these two modes.

The block keeps track of which byte comes next and keeps a request flag that tells the host when the core has a word ready or is waiting for one. On the core side there are three operations: a full 16-bit load of the data register, a handshaking read of the data register, and an immediate write to the status register that leaves a fixed set of bits alone.

Byte sequencing is a two-state machine. In state BYTE_LO the next transfer uses the low byte. In state BYTE_HI it uses the high byte. A host data transfer in 16-bit mode takes BYTE_LO to BYTE_HI, which is the "first byte done" transition. A second transfer takes BYTE_HI back to BYTE_LO, the "word done" transition. Reset returns the machine to BYTE_LO. In 8-bit mode the machine holds its state.

Top module: `hostdr_port`

## Requirements
- R1: After synchronous reset, the data register is 0x0000 and the status word is 0x0000. That means the request flag (status bit 15) is 0, the byte-select flag (status bit 12) is 0, and the width bit (status bit 10) is 0, which selects 16-bit mode.
- R2: A host access with the select low is a status access. Its read data is status bits 15:8. A host write with the select low changes neither the data register nor the status word.
- R3: In 16-bit mode, when the byte-select flag is 0, a host data transfer uses the low byte of the data register and then sets the byte-select flag.
- R4: In 16-bit mode, when the byte-select flag is 1, a host data transfer uses the high byte, then clears both the byte-select flag and the request flag.
- R5: In 8-bit mode (status bit 10 = 1), every host data transfer uses the low byte and clears the request flag. A host write keeps the high byte, and the byte-select flag is left unchanged.
- R6: A core load writes all 16 bits of the data register and sets the request flag. A core handshaking read sets the request flag and leaves the data register unchanged.
- R7: A core status write keeps status bits 15, 12 and 6..2 (mask 0x907C) and replaces every other bit with the written value.
- R8: A host data transfer in the same cycle as a core load is dropped. The data register takes the core value, the byte-select flag keeps its value, and the request flag becomes 1.
- R9: Host read data is combinational. It reflects the current state with no strobe asserted, and a read strobe never changes the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_sel | input | 1 | 0 = status access, 1 = data register access |
| host_rd | input | 1 | Single-cycle host read strobe |
| host_wr | input | 1 | Single-cycle host write strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte (combinational) |
| core_dr_ld | input | 1 | Core loads the data register |
| core_dr_wdata | input | 16 | Core data register value |
| core_dr_hsrd | input | 1 | Core handshaking read of the data register |
| core_sr_wr | input | 1 | Core immediate status write |
| core_sr_wdata | input | 16 | Core status write value |
| dr_q | output | 16 | Current data register |
| sr_q | output | 16 | Current status word |

## Verification
A wrong byte-select state shows up on the very next host data access: host_rdata carries the wrong half of the word, or a host write lands in the wrong half of dr_q. The same fault is visible at once in bit 12 of sr_q. A request flag that fails to set or clear shows up in bit 15 of sr_q one cycle after the strobe or core operation. The bench reads these ports right after each single transfer, so a fault is caught within one cycle of the event that caused it.

// File: rtl/hdp_pkg.sv
package hdp_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    localparam int SR_REQ_BIT = 15;
    localparam int SR_SEL_BIT = 12;
    localparam int SR_WID_BIT = 10;

    typedef enum logic {
        BYTE_LO = 1'b0,
        BYTE_HI = 1'b1
    } byte_sel_e;
endpackage

// File: rtl/hdp_seq.sv
module hdp_seq
    import hdp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      xfer,
    input  logic      wide,
    input  logic      core_arm,
    output byte_sel_e state,
    output logic      req
);
    byte_sel_e state_nxt;
    logic      req_nxt;
    logic      last_byte;

    always_comb begin
        state_nxt = state;
        unique case (state)
            BYTE_LO: if (xfer && wide) state_nxt = BYTE_HI;
            BYTE_HI: if (xfer && wide) state_nxt = BYTE_LO;
        endcase
    end

    assign last_byte = xfer && (!wide || state == BYTE_HI);

    always_comb begin
        req_nxt = req;
        if (core_arm)
            req_nxt = 1'b1;
        else if (last_byte)
            req_nxt = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= BYTE_LO;
            req   <= 1'b0;
        end else begin
            state <= state_nxt;
            req   <= req_nxt;
        end
    end

    // R3: the first byte of a 16-bit word moves to the high byte
    a_r3_first_sets_sel: assert property (@(posedge clk) disable iff (rst)
        (xfer && wide && state == BYTE_LO) |=> (state == BYTE_HI));

    // R4: the second byte of a 16-bit word closes the word
    a_r4_second_closes: assert property (@(posedge clk) disable iff (rst)
        (xfer && wide && state == BYTE_HI && !core_arm) |=> (state == BYTE_LO && !req));

    // R5: in 8-bit mode the byte select holds and the request drops
    a_r5_narrow_holds_sel: assert property (@(posedge clk) disable iff (rst)
        (xfer && !wide && !core_arm) |=> ($stable(state) && !req));

    // R6: any core arming leaves the request raised
    a_r6_arm_sets_req: assert property (@(posedge clk) disable iff (rst)
        core_arm |=> req);
endmodule

// File: rtl/hdp_dreg.sv
module hdp_dreg
    import hdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic              host_hi,
    input  logic [BYTE_W-1:0] host_byte,
    input  logic              core_ld,
    input  logic [WORD_W-1:0] core_word,
    output logic [WORD_W-1:0] dr
);
    logic [BYTE_W-1:0] lo_q, hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (core_ld) begin
            lo_q <= core_word[BYTE_W-1:0];
            hi_q <= core_word[WORD_W-1:BYTE_W];
        end else if (host_we) begin
            if (host_hi) hi_q <= host_byte;
            else         lo_q <= host_byte;
        end
    end

    assign dr = {hi_q, lo_q};

    // R5: a low-byte host write keeps the high byte
    a_r5_low_write_keeps_high: assert property (@(posedge clk) disable iff (rst)
        (host_we && !host_hi && !core_ld) |=> (dr[WORD_W-1:BYTE_W] == $past(dr[WORD_W-1:BYTE_W])));

    // R8: a core load wins over a same-cycle host write
    a_r8_core_wins: assert property (@(posedge clk) disable iff (rst)
        core_ld |=> (dr == $past(core_word)));

    // R9: with no write of any kind the register holds
    a_r9_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!host_we && !core_ld) |=> $stable(dr));
endmodule

// File: rtl/hdp_sreg.sv
module hdp_sreg
    import hdp_pkg::*;
#(
    parameter logic [15:0] KEEP_MASK = 16'h907C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              req,
    input  logic              sel_hi,
    output logic [WORD_W-1:0] sr,
    output logic              narrow
);
    localparam logic [WORD_W-1:0] FLAG_MASK =
        (WORD_W'(1) << SR_REQ_BIT) | (WORD_W'(1) << SR_SEL_BIT);

    logic [WORD_W-1:0] store;
    logic [WORD_W-1:0] flags;

    always_ff @(posedge clk) begin
        if (rst)
            store <= '0;
        else if (wr)
            store <= (store & KEEP_MASK) | (wdata & ~KEEP_MASK & ~FLAG_MASK);
    end

    always_comb begin
        flags = '0;
        flags[SR_REQ_BIT] = req;
        flags[SR_SEL_BIT] = sel_hi;
    end

    assign sr     = store | flags;
    assign narrow = store[SR_WID_BIT];

    // R7: the kept bits of the stored status survive a core write
    a_r7_keep_mask: assert property (@(posedge clk) disable iff (rst)
        wr |=> ((store & KEEP_MASK) == ($past(store) & KEEP_MASK)));

    // R7: the other bits take the written value
    a_r7_replace: assert property (@(posedge clk) disable iff (rst)
        wr |=> ((store & ~KEEP_MASK) == ($past(wdata) & ~KEEP_MASK)));
endmodule

// File: rtl/hostdr_port.sv
module hostdr_port
    import hdp_pkg::*;
#(
    parameter logic [15:0] SR_KEEP_MASK = 16'h907C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_sel,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    input  logic              core_dr_ld,
    input  logic [WORD_W-1:0] core_dr_wdata,
    input  logic              core_dr_hsrd,
    input  logic              core_sr_wr,
    input  logic [WORD_W-1:0] core_sr_wdata,
    output logic [WORD_W-1:0] dr_q,
    output logic [WORD_W-1:0] sr_q
);
    byte_sel_e state;
    logic      req;
    logic      narrow;
    logic      xfer;
    logic      use_hi;

    assign xfer   = host_sel && (host_rd || host_wr) && !core_dr_ld;
    assign use_hi = !narrow && (state == BYTE_HI);

    hdp_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .xfer     (xfer),
        .wide     (!narrow),
        .core_arm (core_dr_ld || core_dr_hsrd),
        .state    (state),
        .req      (req)
    );

    hdp_dreg u_dreg (
        .clk       (clk),
        .rst       (rst),
        .host_we   (xfer && host_wr),
        .host_hi   (use_hi),
        .host_byte (host_wdata),
        .core_ld   (core_dr_ld),
        .core_word (core_dr_wdata),
        .dr        (dr_q)
    );

    hdp_sreg #(.KEEP_MASK(SR_KEEP_MASK)) u_sreg (
        .clk    (clk),
        .rst    (rst),
        .wr     (core_sr_wr),
        .wdata  (core_sr_wdata),
        .req    (req),
        .sel_hi (state == BYTE_HI),
        .sr     (sr_q),
        .narrow (narrow)
    );

    always_comb begin
        if (!host_sel)
            host_rdata = sr_q[WORD_W-1:BYTE_W];
        else if (use_hi)
            host_rdata = dr_q[WORD_W-1:BYTE_W];
        else
            host_rdata = dr_q[BYTE_W-1:0];
    end

    // R2: a host status write leaves the data register and the flags alone
    a_r2_status_write_inert: assert property (@(posedge clk) disable iff (rst)
        (!host_sel && host_wr && !core_dr_ld && !core_dr_hsrd && !core_sr_wr)
            |=> ($stable(dr_q) && $stable(sr_q)));

    // R1: the status word is zero in the first cycle after reset
    a_r1_reset_state: assert property (@(posedge clk)
        $past(rst) |-> (sr_q == '0 && dr_q == '0));
endmodule

// File: tb/sim_hostdr_port.sv
module sim_hostdr_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_sel = 1'b0, host_rd = 1'b0, host_wr = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        core_dr_ld = 1'b0, core_dr_hsrd = 1'b0, core_sr_wr = 1'b0;
    logic [15:0] core_dr_wdata = '0, core_sr_wdata = '0;
    logic [15:0] dr_q, sr_q;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hostdr_port u0 (
        .clk(clk), .rst(rst),
        .host_sel(host_sel), .host_rd(host_rd), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .core_dr_ld(core_dr_ld), .core_dr_wdata(core_dr_wdata),
        .core_dr_hsrd(core_dr_hsrd),
        .core_sr_wr(core_sr_wr), .core_sr_wdata(core_sr_wdata),
        .dr_q(dr_q), .sr_q(sr_q)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic core_load(input logic [15:0] v);
        @(negedge clk); core_dr_ld = 1'b1; core_dr_wdata = v;
        @(negedge clk); core_dr_ld = 1'b0; #1;
    endtask

    task automatic core_status(input logic [15:0] v);
        @(negedge clk); core_sr_wr = 1'b1; core_sr_wdata = v;
        @(negedge clk); core_sr_wr = 1'b0; #1;
    endtask

    task automatic host_read(input logic sel, input string req, input logic [7:0] exp);
        @(negedge clk); host_sel = sel; host_rd = 1'b1; #1;
        chk(req, {8'h00, host_rdata}, {8'h00, exp});
        @(negedge clk); host_rd = 1'b0; #1;
    endtask

    task automatic host_write(input logic sel, input logic [7:0] v);
        @(negedge clk); host_sel = sel; host_wr = 1'b1; host_wdata = v;
        @(negedge clk); host_wr = 1'b0; #1;
    endtask

    task automatic t_reset;
        chk("R1 sr", sr_q, 16'h0000);
        chk("R1 dr", dr_q, 16'h0000);
    endtask

    task automatic t_wide_read;
        core_load(16'hA55A);
        chk("R6 load dr", dr_q, 16'hA55A);
        chk("R6 load req", sr_q, 16'h8000);
        host_read(1'b1, "R3 low byte", 8'h5A);
        chk("R3 sel set", sr_q, 16'h9000);
        host_read(1'b1, "R4 high byte", 8'hA5);
        chk("R4 closed", sr_q, 16'h0000);
    endtask

    task automatic t_wide_write;
        host_write(1'b1, 8'h34);
        chk("R3 write sel", sr_q, 16'h1000);
        chk("R3 write low", dr_q, 16'hA534);
        host_write(1'b1, 8'h12);
        chk("R4 write word", dr_q, 16'h1234);
        chk("R4 write flags", sr_q, 16'h0000);
    endtask

    task automatic t_status;
        core_status(16'hFFFF);
        chk("R7 fill", sr_q, 16'h6F83);
        host_read(1'b0, "R2 status byte", 8'h6F);
        host_write(1'b0, 8'h00);
        chk("R2 write inert sr", sr_q, 16'h6F83);
        chk("R2 write inert dr", dr_q, 16'h1234);
        core_load(16'hBEEF);
        core_status(16'h0000);
        chk("R7 keeps req", sr_q, 16'h8000);
    endtask

    task automatic t_narrow;
        core_status(16'h0400);
        chk("R5 mode", sr_q, 16'h8400);
        host_read(1'b1, "R5 read low", 8'hEF);
        chk("R5 req cleared", sr_q, 16'h0400);
        host_read(1'b1, "R5 read low again", 8'hEF);
        host_write(1'b1, 8'h77);
        chk("R5 keep high", dr_q, 16'hBE77);
        @(negedge clk); core_dr_hsrd = 1'b1;
        @(negedge clk); core_dr_hsrd = 1'b0; #1;
        chk("R6 hs read req", sr_q, 16'h8400);
        chk("R6 hs read dr", dr_q, 16'hBE77);
    endtask

    task automatic t_collision;
        core_status(16'h0000);
        @(negedge clk); host_sel = 1'b1; host_wr = 1'b1; host_wdata = 8'h11;
        core_dr_ld = 1'b1; core_dr_wdata = 16'hCAFE;
        @(negedge clk); host_wr = 1'b0; core_dr_ld = 1'b0; #1;
        chk("R8 core wins dr", dr_q, 16'hCAFE);
        chk("R8 flags", sr_q, 16'h8000);
        host_sel = 1'b1; #1;
        chk("R9 idle low", {8'h00, host_rdata}, 16'h00FE);
        host_sel = 1'b0; #1;
        chk("R9 idle status", {8'h00, host_rdata}, 16'h0080);
        host_read(1'b1, "R9 strobed low", 8'hFE);
        chk("R9 read keeps dr", dr_q, 16'hCAFE);
        chk("R3 sel after read", sr_q, 16'h9000);
        core_status(16'h0400);
        chk("R7 keeps sel", sr_q, 16'h9400);
        host_read(1'b1, "R5 narrow uses low", 8'hFE);
        chk("R5 sel unchanged", sr_q, 16'h1400);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset;
        t_wide_read;
        t_wide_write;
        t_status;
        t_narrow;
        t_collision;
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule